// File: doc/BRIEF.md
# Multi-width aliased register file

A file of sixteen 16-bit general registers whose storage can be addressed through four views: single bytes, single words, 32-bit pairs and 64-bit quads. Each of the two read ports and the one write port takes an access size and a 4-bit designator. A read returns the selected bits right-justified on a 64-bit bus. A write updates only the bits that the view covers.

Register 15 is the stack pointer. It is banked: a mode input picks a supervisor copy or a user copy. Every access to register 15, whether alone or as part of the pair at 14 or the quad at 12, goes to the copy that the mode selects in that cycle. The stack pointer of the current mode is also driven on a dedicated output.

A pair designator must be even and a quad designator must be a multiple of four. A misaligned designator flags an error on its port. On a read it forces the data to zero. On the write port it blocks the write.

Top module: `regfile_alias`

## Requirements
- R1: After reset every register and both stack copies are zero, so every read and `sp_o` return zero.
- R2: Size code 1 (word) with designator k reads or writes register k. Read data sits in bits [15:0] and bits [63:16] are zero. A word access never flags an error.
- R3: Size code 0 (byte) never flags an error. Designator values 0-7 select the high byte (bits [15:8]) of registers 0-7. Values 8-15 select the low byte (bits [7:0]) of registers 0-7. Read data sits in bits [7:0] and the rest is zero. A byte write takes data bits [7:0] and leaves the other byte of the register unchanged.
- R4: Size code 2 (pair) with an even designator k covers registers k and k+1. Register k occupies bits [31:16] and k+1 occupies bits [15:0]. Bits [63:32] of read data are zero.
- R5: Size code 3 (quad) with designator k, a multiple of 4, covers registers k to k+3. Register k occupies bits [63:48] and k+3 occupies bits [15:0].
- R6: An odd pair designator, or a quad designator that is not a multiple of 4, raises that port's error output. A read port in error returns zero data. A write in error (`wr_err_o` high while `wr_en_i` is high) changes no register.
- R7: Accesses to register 15 go to the supervisor copy when `sup_mode_i` is 1 and to the user copy when it is 0. `sp_o` shows the copy that the current mode selects.
- R8: A read that hits bits being written in the same cycle returns the old value. The new value is readable from the next cycle.
- R9: The two read ports are independent and can select different sizes and designators in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sup_mode_i | input | 1 | 1 = supervisor stack copy, 0 = user stack copy |
| rd_a_size_i | input | 2 | Read port A access size (0 byte, 1 word, 2 pair, 3 quad) |
| rd_a_idx_i | input | 4 | Read port A designator |
| rd_a_data_o | output | 64 | Read port A data, right-justified |
| rd_a_err_o | output | 1 | Read port A misaligned designator |
| rd_b_size_i | input | 2 | Read port B access size |
| rd_b_idx_i | input | 4 | Read port B designator |
| rd_b_data_o | output | 64 | Read port B data, right-justified |
| rd_b_err_o | output | 1 | Read port B misaligned designator |
| wr_en_i | input | 1 | Write enable |
| wr_size_i | input | 2 | Write access size |
| wr_idx_i | input | 4 | Write designator |
| wr_data_i | input | 64 | Write data, right-justified |
| wr_err_o | output | 1 | Write rejected for misalignment |
| sp_o | output | 16 | Stack pointer of the current mode |

## Verification
A read and a write to the same bits can fall in the same cycle. A second case is a write to register 15 in the same cycle that the mode input selects the bank.

The bench sweeps every size, every designator and both modes. In each step, read port A targets exactly the bits being written, and the value it returns during the write cycle is compared with the model's old contents. The following cycle it is compared with the new contents. Each write is made with the mode set for that step, and `sp_o` together with the register-15 views is checked against a bench model that keeps both stack copies separate.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_PAIR = 2'd2,
    SZ_QUAD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/rf_align.sv
module rf_align
  import regfile_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic [1:0]       size_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             err_o
);
  always_comb begin
    case (acc_size_e'(size_i))
      SZ_PAIR: err_o = idx_i[0];
      SZ_QUAD: err_o = |idx_i[1:0];
      default: err_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import regfile_pkg::*;
#(
  parameter int REG_W    = 16,
  parameter int NUM_REGS = 16,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int DATA_W  = 4 * REG_W
) (
  input  logic [NUM_REGS*REG_W-1:0] view_i,
  input  logic [1:0]                size_i,
  input  logic [IDX_W-1:0]          idx_i,
  output logic [DATA_W-1:0]         data_o,
  output logic                      err_o
);
  localparam int BYTE_W = REG_W / 2;
  localparam logic [IDX_W-1:0] HALF = IDX_W'(NUM_REGS / 2);

  logic             lo_sel;
  logic [IDX_W-1:0] base;
  logic [REG_W-1:0] w0, w1, w2, w3;

  rf_align #(.IDX_W(IDX_W)) u_align (
    .size_i(size_i),
    .idx_i (idx_i),
    .err_o (err_o)
  );

  assign lo_sel = (idx_i >= HALF);

  always_comb begin
    case (acc_size_e'(size_i))
      SZ_BYTE: base = lo_sel ? idx_i - HALF : idx_i;
      SZ_PAIR: base = {idx_i[IDX_W-1:1], 1'b0};
      SZ_QUAD: base = {idx_i[IDX_W-1:2], 2'b00};
      default: base = idx_i;
    endcase
  end

  assign w0 = view_i[int'(base)*REG_W +: REG_W];
  assign w1 = view_i[int'(base + IDX_W'(1))*REG_W +: REG_W];
  assign w2 = view_i[int'(base + IDX_W'(2))*REG_W +: REG_W];
  assign w3 = view_i[int'(base + IDX_W'(3))*REG_W +: REG_W];

  always_comb begin
    data_o = '0;
    if (!err_o) begin
      case (acc_size_e'(size_i))
        SZ_BYTE: data_o[BYTE_W-1:0] = lo_sel ? w0[BYTE_W-1:0] : w0[REG_W-1 -: BYTE_W];
        SZ_WORD: data_o[REG_W-1:0]   = w0;
        SZ_PAIR: data_o[2*REG_W-1:0] = {w0, w1};
        default: data_o              = {w0, w1, w2, w3};
      endcase
    end
  end
endmodule

// File: rtl/rf_write_lanes.sv
module rf_write_lanes
  import regfile_pkg::*;
#(
  parameter int REG_W    = 16,
  parameter int NUM_REGS = 16,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int DATA_W  = 4 * REG_W
) (
  input  logic                      en_i,
  input  logic [1:0]                size_i,
  input  logic [IDX_W-1:0]          idx_i,
  input  logic [DATA_W-1:0]         data_i,
  output logic                      err_o,
  output logic [NUM_REGS-1:0]       we_hi_o,
  output logic [NUM_REGS-1:0]       we_lo_o,
  output logic [NUM_REGS*REG_W-1:0] val_o
);
  localparam int BYTE_W = REG_W / 2;
  localparam logic [IDX_W-1:0] HALF = IDX_W'(NUM_REGS / 2);

  logic             misalign;
  logic             go;
  logic             lo_sel;
  logic [IDX_W-1:0] byte_reg;

  rf_align #(.IDX_W(IDX_W)) u_align (
    .size_i(size_i),
    .idx_i (idx_i),
    .err_o (misalign)
  );

  assign err_o    = en_i & misalign;
  assign go       = en_i & ~misalign;
  assign lo_sel   = (idx_i >= HALF);
  assign byte_reg = lo_sel ? idx_i - HALF : idx_i;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_lane
    localparam logic [IDX_W-1:0] KI = IDX_W'(k);
    localparam int SP = k % 2;
    localparam int SQ = k % 4;
    logic             hi, lo;
    logic [REG_W-1:0] v;

    always_comb begin
      hi = 1'b0;
      lo = 1'b0;
      v  = data_i[REG_W-1:0];
      case (acc_size_e'(size_i))
        SZ_BYTE: begin
          hi = go & ~lo_sel & (byte_reg == KI);
          lo = go & lo_sel & (byte_reg == KI);
          v  = {2{data_i[BYTE_W-1:0]}};
        end
        SZ_WORD: begin
          hi = go & (idx_i == KI);
          lo = hi;
        end
        SZ_PAIR: begin
          hi = go & (idx_i[IDX_W-1:1] == KI[IDX_W-1:1]);
          lo = hi;
          v  = data_i[(1-SP)*REG_W +: REG_W];
        end
        default: begin
          hi = go & (idx_i[IDX_W-1:2] == KI[IDX_W-1:2]);
          lo = hi;
          v  = data_i[(3-SQ)*REG_W +: REG_W];
        end
      endcase
    end

    assign we_hi_o[k]               = hi;
    assign we_lo_o[k]               = lo;
    assign val_o[k*REG_W +: REG_W]  = v;
  end
endmodule

// File: rtl/regfile_alias.sv
module regfile_alias
  import regfile_pkg::*;
#(
  parameter int REG_W    = 16,
  parameter int NUM_REGS = 16,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int DATA_W  = 4 * REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sup_mode_i,
  input  logic [1:0]        rd_a_size_i,
  input  logic [IDX_W-1:0]  rd_a_idx_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  output logic              rd_a_err_o,
  input  logic [1:0]        rd_b_size_i,
  input  logic [IDX_W-1:0]  rd_b_idx_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  output logic              rd_b_err_o,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_size_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_err_o,
  output logic [REG_W-1:0]  sp_o
);
  localparam int BYTE_W = REG_W / 2;
  localparam int SP_IDX = NUM_REGS - 1;

  logic [NUM_REGS*REG_W-1:0] view;
  logic [NUM_REGS-1:0]       we_hi, we_lo;
  logic [NUM_REGS*REG_W-1:0] wval;
  logic [REG_W-1:0]          sp_sys_q, sp_usr_q;

  rf_write_lanes #(.REG_W(REG_W), .NUM_REGS(NUM_REGS)) u_wr (
    .en_i   (wr_en_i),
    .size_i (wr_size_i),
    .idx_i  (wr_idx_i),
    .data_i (wr_data_i),
    .err_o  (wr_err_o),
    .we_hi_o(we_hi),
    .we_lo_o(we_lo),
    .val_o  (wval)
  );

  // plain registers below the stack pointer
  for (genvar k = 0; k < SP_IDX; k++) begin : g_gpr
    logic [REG_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '0;
      end else begin
        if (we_hi[k]) q[REG_W-1:BYTE_W] <= wval[k*REG_W+BYTE_W +: REG_W-BYTE_W];
        if (we_lo[k]) q[BYTE_W-1:0]     <= wval[k*REG_W +: BYTE_W];
      end
    end
    assign view[k*REG_W +: REG_W] = q;
  end

  // banked stack pointer, bank picked by the mode of the write cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_sys_q <= '0;
      sp_usr_q <= '0;
    end else if (sup_mode_i) begin
      if (we_hi[SP_IDX]) sp_sys_q[REG_W-1:BYTE_W] <= wval[SP_IDX*REG_W+BYTE_W +: REG_W-BYTE_W];
      if (we_lo[SP_IDX]) sp_sys_q[BYTE_W-1:0]     <= wval[SP_IDX*REG_W +: BYTE_W];
    end else begin
      if (we_hi[SP_IDX]) sp_usr_q[REG_W-1:BYTE_W] <= wval[SP_IDX*REG_W+BYTE_W +: REG_W-BYTE_W];
      if (we_lo[SP_IDX]) sp_usr_q[BYTE_W-1:0]     <= wval[SP_IDX*REG_W +: BYTE_W];
    end
  end

  assign sp_o = sup_mode_i ? sp_sys_q : sp_usr_q;
  assign view[SP_IDX*REG_W +: REG_W] = sp_o;

  logic [1:0]        rsize [2];
  logic [IDX_W-1:0]  ridx  [2];
  logic [DATA_W-1:0] rdata [2];
  logic [1:0]        rerr;

  assign rsize[0] = rd_a_size_i;
  assign rsize[1] = rd_b_size_i;
  assign ridx[0]  = rd_a_idx_i;
  assign ridx[1]  = rd_b_idx_i;

  for (genvar p = 0; p < 2; p++) begin : g_rd
    rf_read_port #(.REG_W(REG_W), .NUM_REGS(NUM_REGS)) u_port (
      .view_i(view),
      .size_i(rsize[p]),
      .idx_i (ridx[p]),
      .data_o(rdata[p]),
      .err_o (rerr[p])
    );
  end

  assign rd_a_data_o = rdata[0];
  assign rd_a_err_o  = rerr[0];
  assign rd_b_data_o = rdata[1];
  assign rd_b_err_o  = rerr[1];
endmodule

// File: rtl/regfile_alias_chk.sv
module regfile_alias_chk #(
  parameter int REG_W    = 16,
  parameter int NUM_REGS = 16,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int DATA_W  = 4 * REG_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sup_mode_i,
  input logic [1:0]        rd_a_size_i,
  input logic [IDX_W-1:0]  rd_a_idx_i,
  input logic [DATA_W-1:0] rd_a_data_o,
  input logic              rd_a_err_o,
  input logic [1:0]        rd_b_size_i,
  input logic [IDX_W-1:0]  rd_b_idx_i,
  input logic [DATA_W-1:0] rd_b_data_o,
  input logic              rd_b_err_o,
  input logic              wr_en_i,
  input logic [1:0]        wr_size_i,
  input logic [IDX_W-1:0]  wr_idx_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              wr_err_o,
  input logic [REG_W-1:0]  sp_o
);
  localparam logic [IDX_W-1:0] SP_IDX = IDX_W'(NUM_REGS - 1);

  // R2
  word_byte_no_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_b_size_i[1] == 1'b0) |-> !rd_b_err_o);

  // R6
  pair_odd_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_size_i == 2'd2 && rd_a_idx_i[0]) |-> rd_a_err_o);

  // R6
  err_data_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_a_err_o |-> (rd_a_data_o == '0));

  // R6
  wr_err_sp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_err_o) |=> (sup_mode_i != $past(sup_mode_i)) || $stable(sp_o));

  // R7
  sp_bank_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_size_i == 2'd1 && wr_idx_i == SP_IDX)
    |=> (sup_mode_i != $past(sup_mode_i)) || (sp_o == $past(wr_data_i[REG_W-1:0])));

  // R8
  wr_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_i && !wr_err_o && wr_size_i == 2'd1 && wr_idx_i != SP_IDX)
     && rd_a_size_i == 2'd1 && rd_a_idx_i == $past(wr_idx_i))
    |-> (rd_a_data_o[REG_W-1:0] == $past(wr_data_i[REG_W-1:0])));
endmodule

bind regfile_alias regfile_alias_chk #(.REG_W(REG_W), .NUM_REGS(NUM_REGS)) u_chk (.*);

// File: tb/tb_regfile_alias.sv
`timescale 1ns/1ps
module tb_regfile_alias;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sup_mode_i = 1'b0;
  logic [1:0]  rd_a_size_i = 2'd1, rd_b_size_i = 2'd1, wr_size_i = 2'd1;
  logic [3:0]  rd_a_idx_i = '0, rd_b_idx_i = '0, wr_idx_i = '0;
  logic [63:0] rd_a_data_o, rd_b_data_o, wr_data_i = '0;
  logic        rd_a_err_o, rd_b_err_o, wr_en_i = 1'b0, wr_err_o;
  logic [15:0] sp_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [15:0] m [15];
  logic [15:0] sp_s, sp_u;

  always #10 clk_i = ~clk_i;

  regfile_alias dut (.*);

  function automatic logic [15:0] lv(int k, logic md);
    if (k == 15) return md ? sp_s : sp_u;
    return m[k];
  endfunction

  function automatic logic merr(int sz, int idx);
    return (sz == 2 && idx % 2 != 0) || (sz == 3 && idx % 4 != 0);
  endfunction

  function automatic logic [63:0] mread(int sz, int idx, logic md);
    logic [15:0] w;
    if (merr(sz, idx)) return 64'd0;
    case (sz)
      0: begin
        w = lv(idx % 8, md);
        return idx < 8 ? {56'd0, w[15:8]} : {56'd0, w[7:0]};
      end
      1: return {48'd0, lv(idx, md)};
      2: return {32'd0, lv(idx, md), lv(idx + 1, md)};
      default: return {lv(idx, md), lv(idx + 1, md), lv(idx + 2, md), lv(idx + 3, md)};
    endcase
  endfunction

  task automatic mset(int k, logic md, logic [15:0] v);
    if (k < 15) m[k] = v;
    else if (md) sp_s = v;
    else sp_u = v;
  endtask

  task automatic mwrite(int sz, int idx, logic md, logic [63:0] d);
    logic [15:0] w;
    if (merr(sz, idx)) return;
    case (sz)
      0: begin
        w = lv(idx % 8, md);
        if (idx < 8) w[15:8] = d[7:0];
        else w[7:0] = d[7:0];
        mset(idx % 8, md, w);
      end
      1: mset(idx, md, d[15:0]);
      2: begin
        mset(idx, md, d[31:16]);
        mset(idx + 1, md, d[15:0]);
      end
      default: for (int j = 0; j < 4; j++) mset(idx + j, md, d[63-16*j -: 16]);
    endcase
  endtask

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic string size_tag(int sz);
    case (sz)
      0: return "R3 byte";
      1: return "R2 word";
      2: return "R4 pair";
      default: return "R5 quad";
    endcase
  endfunction

  task automatic step(int sz, int idx, logic md, logic [63:0] d);
    logic e;
    int   breg;
    e = merr(sz, idx);
    breg = (sz == 0) ? idx % 8 : idx;
    @(negedge clk_i);
    sup_mode_i  = md;
    wr_en_i     = 1'b1;
    wr_size_i   = 2'(sz);
    wr_idx_i    = 4'(idx);
    wr_data_i   = d;
    rd_a_size_i = 2'(sz);
    rd_a_idx_i  = 4'(idx);
    rd_b_size_i = 2'd1;
    rd_b_idx_i  = 4'((idx + 5) % 16);
    #1;
    chk("R8 old value during write", rd_a_data_o, mread(sz, idx, md));
    chk("R6 read error flag", {63'd0, rd_a_err_o}, {63'd0, e});
    chk("R6 write error flag", {63'd0, wr_err_o}, {63'd0, e});
    chk("R9 port B independent", rd_b_data_o, mread(1, (idx + 5) % 16, md));
    @(posedge clk_i);
    mwrite(sz, idx, md, d);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    if (e) begin
      rd_a_size_i = 2'd1;
      rd_a_idx_i  = 4'(idx);
    end
    rd_b_size_i = 2'd1;
    rd_b_idx_i  = 4'(breg);
    #1;
    if (e) chk("R6 misaligned write suppressed", rd_a_data_o, mread(1, idx, md));
    else   chk(size_tag(sz), rd_a_data_o, mread(sz, idx, md));
    chk("R3 R2 word view after write", rd_b_data_o, mread(1, breg, md));
    chk("R7 sp_o current bank", {48'd0, sp_o}, {48'd0, md ? sp_s : sp_u});
  endtask

  initial begin
    #4000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] d;
    int n;
    for (int k = 0; k < 15; k++) m[k] = '0;
    sp_s = '0;
    sp_u = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset contents
    for (int k = 0; k < 16; k++) begin
      @(negedge clk_i);
      rd_a_size_i = 2'd1;
      rd_a_idx_i  = 4'(k);
      rd_b_size_i = 2'd3;
      rd_b_idx_i  = 4'(k & 12);
      sup_mode_i  = k[0];
      #1;
      chk("R1 reset word", rd_a_data_o, 64'd0);
      chk("R1 reset quad", rd_b_data_o, 64'd0);
      chk("R1 reset sp_o", {48'd0, sp_o}, 64'd0);
    end
    n = 0;
    for (int sz = 0; sz < 4; sz++)
      for (int idx = 0; idx < 16; idx++)
        for (int md = 0; md < 2; md++) begin
          n++;
          d = 64'h9E37_79B9_7F4A_7C15 * 64'(n);
          step(sz, idx, md[0], d);
        end
    // R7 bank separation: same designator, alternating modes
    step(1, 15, 1'b1, 64'h0000_0000_0000_5A5A);
    step(1, 15, 1'b0, 64'h0000_0000_0000_C3C3);
    step(3, 12, 1'b1, 64'h1111_2222_3333_4444);
    step(2, 14, 1'b0, 64'h0000_0000_7777_8888);
    @(negedge clk_i);
    sup_mode_i = 1'b1;
    #1;
    chk("R7 supervisor copy kept", {48'd0, sp_o}, 64'h4444);
    sup_mode_i = 1'b0;
    #1;
    chk("R7 user copy kept", {48'd0, sp_o}, 64'h8888);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule